// File: doc/BRIEF.md
# BCD Clock-Calendar with Host Shadow Registers

This block counts time of day and calendar date in packed BCD: seconds, minutes, hours in 24-hour form, day of week, date, month, two-digit year and a century field. It advances by one second on each cycle in which the one-second enable `sec_tick` is high. That enable comes from an external timebase. Date rollover follows the length of each month, and February gets a leap-year correction.

A host reaches the time through a byte-wide register port with a 4-bit address, chip select, write enable and read enable. The host sees a shadow copy of the counters, not the counters themselves. While no control bit is set, the shadow is refreshed on every tick. A hold bit freezes the shadow so that a multi-byte read is coherent, while the counters keep running. A set bit stops refreshes so the host can stage a new time. Clearing the set bit copies the staged values into the counters. A stop bit gates the tick, and a spare test bit is stored and read back.

Top module: `clkcal_top`

## Requirements
- R1: After reset the counters and the shadow hold 00:00:00, day 1, date 01, month 01, year 00, century 00. The set, hold, stop and test bits are all 0.
- R2: Register map. Each field is right-aligned, and unused bits read 0.
  - 8h: control. Bit 7 is the set bit, bit 6 is the hold bit, bits 5:0 are the century.
  - 9h: seconds in bits 6:0, with the stop bit in bit 7.
  - Ah: minutes in bits 6:0.
  - Bh: hours in bits 5:0.
  - Ch: day of week in bits 2:0, with the test bit in bit 6.
  - Dh: date in bits 5:0.
  - Eh: month in bits 4:0.
  - Fh: year, all 8 bits.
  - `rdata` is 0 whenever `cs` and `re` are not both high.
- R3: Seconds wrap 59→00 and carry into minutes. Minutes wrap 59→00 and carry into hours. Hours wrap 23→00 and advance both the date and the day of week. The day of week wraps 7→1.
- R4: The date wraps to 01 after the last day of the month: 31 for months 01, 03, 05, 07, 08, 10 and 12, and 30 for months 04, 06, 09 and 11.
- R5: February ends at 29 when the year value (00-99) is divisible by 4, and at 28 otherwise.
- R6: Month 12 wraps to 01 and carries into the year. Year 99 wraps to 00 and carries into the century. Century 39 wraps to 00.
- R7: With the set and hold bits both 0, a tick updates the shadow in the same clock edge to the newly advanced count.
- R8: While the hold bit is 1, the shadow keeps its values and the counters still advance. After the hold bit is cleared, the next tick shows the current count.
- R9: While the set bit is 1, ticks do not reach the shadow, and host writes to 9h-Fh land in the shadow only. A write to 8h with bit 7 = 0, while the set bit is 1, loads the shadow into the counters. The century for that load comes from the same write.
- R10: While the stop bit is 1, ticks do not advance the counters. Once it is 0, counting resumes.
- R11: The test bit is cleared by reset, reads back as written, and does not affect counting.
- R12: A host write to a shadow register in the same cycle as a refresh wins for that register.
- R13: Writes to addresses 0h-7h change nothing, and unused bits written as 1 read back 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sec_tick | input | 1 | One-second advance enable, one cycle wide |
| bus_cs | input | 1 | Register port select |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read enable |
| bus_addr | input | 4 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from address |

## Verification
Time is preloaded just before a boundary, and ticks are then applied. The preloaded points are:
- every month-end class: 30-day, 31-day, leap February and common February;
- the year-end and century-end cascade;
- a day-of-week value of 7.

These cases separate a wrong month-length table from a wrong carry chain. Ticks are also applied under each control state: free running, hold set, set bit set and stop bit set. This shows whether a fault sits in the shadow path or in the counter path, since a frozen shadow over a running counter shows up only after hold is released. A write that collides with a tick, writes to the empty low addresses, and a reset taken in the middle of a run check the priority rules and the cleared test bit.

// File: rtl/clkcal_pkg.sv
package clkcal_pkg;

  localparam int ADDR_W = 4;
  localparam int DATA_W = 8;

  localparam logic [ADDR_W-1:0] OFS_CTRL = 4'h8;
  localparam logic [ADDR_W-1:0] OFS_SEC  = 4'h9;
  localparam logic [ADDR_W-1:0] OFS_MIN  = 4'hA;
  localparam logic [ADDR_W-1:0] OFS_HR   = 4'hB;
  localparam logic [ADDR_W-1:0] OFS_DOW  = 4'hC;
  localparam logic [ADDR_W-1:0] OFS_DATE = 4'hD;
  localparam logic [ADDR_W-1:0] OFS_MON  = 4'hE;
  localparam logic [ADDR_W-1:0] OFS_YR   = 4'hF;

  typedef struct packed {
    logic [5:0] cen;
    logic [7:0] yr;
    logic [4:0] mon;
    logic [5:0] date;
    logic [2:0] dow;
    logic [5:0] hr;
    logic [6:0] min;
    logic [6:0] sec;
  } cal_t;

  localparam cal_t CAL_RESET = '{cen: 6'h00, yr: 8'h00, mon: 5'h01,
                                 date: 6'h01, dow: 3'd1, hr: 6'h00,
                                 min: 7'h00, sec: 7'h00};

  // Add one to a two-digit packed BCD value.
  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    logic [7:0] r;
    if (v[3:0] >= 4'd9) r = {v[7:4] + 4'd1, 4'd0};
    else                r = {v[7:4], v[3:0] + 4'd1};
    return r;
  endfunction

  // Leap rule: binary value of the BCD year divisible by four.
  function automatic logic is_leap(input logic [7:0] yr);
    logic [6:0] b;
    b = {3'b000, yr[7:4]} * 7'd10 + {3'b000, yr[3:0]};
    return (b[1:0] == 2'b00);
  endfunction

  // Last date of a month, in BCD.
  function automatic logic [5:0] month_last(input logic [4:0] mon,
                                            input logic [7:0] yr);
    logic [5:0] r;
    case (mon)
      5'h02:                      r = is_leap(yr) ? 6'h29 : 6'h28;
      5'h04, 5'h06, 5'h09, 5'h11: r = 6'h30;
      default:                    r = 6'h31;
    endcase
    return r;
  endfunction

  // One-second step of the whole calendar, with the carry chain.
  function automatic cal_t cal_advance(input cal_t c, input logic [5:0] cen_last);
    cal_t n;
    logic [7:0] t;
    n = c;
    if (c.sec < 7'h59) begin
      t = bcd_inc({1'b0, c.sec}); n.sec = t[6:0];
    end else begin
      n.sec = '0;
      if (c.min < 7'h59) begin
        t = bcd_inc({1'b0, c.min}); n.min = t[6:0];
      end else begin
        n.min = '0;
        if (c.hr < 6'h23) begin
          t = bcd_inc({2'b00, c.hr}); n.hr = t[5:0];
        end else begin
          n.hr  = '0;
          n.dow = (c.dow >= 3'd7) ? 3'd1 : c.dow + 3'd1;
          if (c.date < month_last(c.mon, c.yr)) begin
            t = bcd_inc({2'b00, c.date}); n.date = t[5:0];
          end else begin
            n.date = 6'h01;
            if (c.mon < 5'h12) begin
              t = bcd_inc({3'b000, c.mon}); n.mon = t[4:0];
            end else begin
              n.mon = 5'h01;
              if (c.yr != 8'h99) begin
                n.yr = bcd_inc(c.yr);
              end else begin
                n.yr = '0;
                if (c.cen < cen_last) begin
                  t = bcd_inc({2'b00, c.cen}); n.cen = t[5:0];
                end else begin
                  n.cen = '0;
                end
              end
            end
          end
        end
      end
    end
    return n;
  endfunction

endpackage

// File: rtl/clkcal_core.sv
module clkcal_core
  import clkcal_pkg::*;
#(
  parameter logic [5:0] CENTURY_LAST = 6'h39
) (
  input  logic clk,
  input  logic rst_n,
  input  logic adv_en,
  input  logic load_en,
  input  cal_t load_val,
  output cal_t cnt_q,
  output cal_t cnt_nxt
);

  always_comb begin
    cnt_nxt = adv_en ? cal_advance(cnt_q, CENTURY_LAST) : cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= CAL_RESET;
    else if (load_en) cnt_q <= load_val;
    else              cnt_q <= cnt_nxt;
  end

endmodule

// File: rtl/clkcal_regs.sv
module clkcal_regs
  import clkcal_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs,
  input  logic              we,
  input  logic              re,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              refresh_en,
  input  cal_t              cnt_nxt,
  output cal_t              user_q,
  output logic              w_bit,
  output logic              r_bit,
  output logic              osc_stop,
  output logic              ft_bit,
  output logic              load_en,
  output cal_t              load_val,
  output logic [DATA_W-1:0] rdata
);

  logic wr_en;
  assign wr_en   = cs & we;
  assign load_en = wr_en && (addr == OFS_CTRL) && w_bit && !wdata[7];

  always_comb begin
    load_val     = user_q;
    load_val.cen = wdata[5:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      user_q   <= CAL_RESET;
      w_bit    <= 1'b0;
      r_bit    <= 1'b0;
      osc_stop <= 1'b0;
      ft_bit   <= 1'b0;
    end else begin
      if (refresh_en) user_q <= cnt_nxt;
      if (wr_en) begin
        case (addr)
          OFS_CTRL: begin
            w_bit      <= wdata[7];
            r_bit      <= wdata[6];
            user_q.cen <= wdata[5:0];
          end
          OFS_SEC: begin
            osc_stop   <= wdata[7];
            user_q.sec <= wdata[6:0];
          end
          OFS_MIN:  user_q.min  <= wdata[6:0];
          OFS_HR:   user_q.hr   <= wdata[5:0];
          OFS_DOW: begin
            ft_bit     <= wdata[6];
            user_q.dow <= wdata[2:0];
          end
          OFS_DATE: user_q.date <= wdata[5:0];
          OFS_MON:  user_q.mon  <= wdata[4:0];
          OFS_YR:   user_q.yr   <= wdata;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    rdata = '0;
    if (cs && re) begin
      case (addr)
        OFS_CTRL: rdata = {w_bit, r_bit, user_q.cen};
        OFS_SEC:  rdata = {osc_stop, user_q.sec};
        OFS_MIN:  rdata = {1'b0, user_q.min};
        OFS_HR:   rdata = {2'b00, user_q.hr};
        OFS_DOW:  rdata = {1'b0, ft_bit, 3'b000, user_q.dow};
        OFS_DATE: rdata = {2'b00, user_q.date};
        OFS_MON:  rdata = {3'b000, user_q.mon};
        OFS_YR:   rdata = user_q.yr;
        default:  rdata = '0;
      endcase
    end
  end

endmodule

// File: rtl/clkcal_top.sv
module clkcal_top
  import clkcal_pkg::*;
#(
  parameter logic [5:0] CENTURY_LAST = 6'h39
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sec_tick,
  input  logic              bus_cs,
  input  logic              bus_we,
  input  logic              bus_re,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata
);

  cal_t cnt_q, cnt_nxt, user_q, load_val;
  logic w_bit, r_bit, osc_stop, ft_bit;
  logic adv_en, load_en, refresh_en;

  // Named events used by the checker
  assign adv_en     = sec_tick & ~osc_stop;
  assign refresh_en = sec_tick & ~w_bit & ~r_bit;

  clkcal_core #(.CENTURY_LAST(CENTURY_LAST)) core_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .adv_en   (adv_en),
    .load_en  (load_en),
    .load_val (load_val),
    .cnt_q    (cnt_q),
    .cnt_nxt  (cnt_nxt)
  );

  clkcal_regs regs_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .cs         (bus_cs),
    .we         (bus_we),
    .re         (bus_re),
    .addr       (bus_addr),
    .wdata      (bus_wdata),
    .refresh_en (refresh_en),
    .cnt_nxt    (cnt_nxt),
    .user_q     (user_q),
    .w_bit      (w_bit),
    .r_bit      (r_bit),
    .osc_stop   (osc_stop),
    .ft_bit     (ft_bit),
    .load_en    (load_en),
    .load_val   (load_val),
    .rdata      (bus_rdata)
  );

endmodule

// File: rtl/clkcal_chk.sv
module clkcal_chk
  import clkcal_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              bus_cs,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              adv_en,
  input logic              load_en,
  input logic              refresh_en,
  input logic              r_bit,
  input logic              osc_stop,
  input logic              ft_bit,
  input cal_t              user_q,
  input cal_t              cnt_q,
  input cal_t              load_val
);

  // R3
  sec_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_en && !load_en && cnt_q.sec == 7'h59) |=> (cnt_q.sec == 7'h00));

  // R7
  refresh_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (refresh_en && !(bus_cs && bus_we)) |=> (user_q == cnt_q));

  // R8
  freeze_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (r_bit && !(bus_cs && bus_we)) |=> $stable(user_q));

  // R9
  load_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |=> (cnt_q == $past(load_val)));

  // R10
  stop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (osc_stop && !load_en) |=> $stable(cnt_q));

  // R11
  ft_reset_chk: assert property (@(posedge clk)
    !rst_n |=> !ft_bit);

  // R12
  wr_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_cs && bus_we && bus_addr == OFS_MIN) |=> (user_q.min == $past(bus_wdata[6:0])));

endmodule

bind clkcal_top clkcal_chk chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_cs     (bus_cs),
  .bus_we     (bus_we),
  .bus_addr   (bus_addr),
  .bus_wdata  (bus_wdata),
  .adv_en     (adv_en),
  .load_en    (load_en),
  .refresh_en (refresh_en),
  .r_bit      (r_bit),
  .osc_stop   (osc_stop),
  .ft_bit     (ft_bit),
  .user_q     (user_q),
  .cnt_q      (cnt_q),
  .load_val   (load_val)
);

// File: tb/clkcal_top_tb_top.sv
module clkcal_top_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sec_tick = 1'b0;
  logic       bus_cs = 1'b0, bus_we = 1'b0, bus_re = 1'b0;
  logic [3:0] bus_addr = 4'h0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;

  always #10 clk = ~clk;   // 50 MHz

  clkcal_top dut_i (
    .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick),
    .bus_cs(bus_cs), .bus_we(bus_we), .bus_re(bus_re),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  int    total = 0, bad = 0;
  bit    chk_en = 0, done = 0;
  string cur_req = "R1";

  // Reference model, plain integers. Index: 0 sec,1 min,2 hour,3 dow,4 date,5 month,6 year,7 century
  int m[8], u[8], n[8];
  bit osc = 0, ft = 0, wb = 0, rb = 0;

  function automatic int bin(input int x);
    return ((x >> 4) & 15) * 10 + (x & 15);
  endfunction

  function automatic int bcd(input int v);
    return ((v / 10) << 4) | (v % 10);
  endfunction

  function automatic int mdays(input int mo, input int y);
    if (mo == 2) return (y % 4 == 0) ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m = '{0, 0, 0, 1, 1, 1, 0, 0};
      u = m;
      osc = 0; ft = 0; wb = 0; rb = 0;
    end else begin
      n = m;
      if (sec_tick && !osc) begin
        n[0]++;
        if (n[0] == 60) begin
          n[0] = 0; n[1]++;
          if (n[1] == 60) begin
            n[1] = 0; n[2]++;
            if (n[2] == 24) begin
              n[2] = 0; n[3] = n[3] % 7 + 1; n[4]++;
              if (n[4] > mdays(n[5], n[6])) begin
                n[4] = 1; n[5]++;
                if (n[5] == 13) begin
                  n[5] = 1; n[6]++;
                  if (n[6] == 100) begin
                    n[6] = 0; n[7] = (n[7] + 1) % 40;
                  end
                end
              end
            end
          end
        end
      end
      if (bus_cs && bus_we && bus_addr == 4'h8 && wb && !bus_wdata[7]) begin
        m = u; m[7] = bin(int'(bus_wdata[5:0]));
      end else begin
        m = n;
      end
      if (sec_tick && !rb && !wb) u = n;
      if (bus_cs && bus_we) begin
        case (bus_addr)
          4'h8: begin wb = bus_wdata[7]; rb = bus_wdata[6]; u[7] = bin(int'(bus_wdata[5:0])); end
          4'h9: begin osc = bus_wdata[7]; u[0] = bin(int'(bus_wdata[6:0])); end
          4'hA: u[1] = bin(int'(bus_wdata[6:0]));
          4'hB: u[2] = bin(int'(bus_wdata[5:0]));
          4'hC: begin ft = bus_wdata[6]; u[3] = int'(bus_wdata[2:0]); end
          4'hD: u[4] = bin(int'(bus_wdata[5:0]));
          4'hE: u[5] = bin(int'(bus_wdata[4:0]));
          4'hF: u[6] = bin(int'(bus_wdata));
          default: ;
        endcase
      end
    end
  end

  function automatic int exp_rd();
    if (!(bus_cs && bus_re)) return 0;
    case (bus_addr)
      4'h8: return (int'(wb) << 7) | (int'(rb) << 6) | bcd(u[7]);
      4'h9: return (int'(osc) << 7) | bcd(u[0]);
      4'hA: return bcd(u[1]);
      4'hB: return bcd(u[2]);
      4'hC: return (int'(ft) << 6) | u[3];
      4'hD: return bcd(u[4]);
      4'hE: return bcd(u[5]);
      4'hF: return bcd(u[6]);
      default: return 0;
    endcase
  endfunction

  // Compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (chk_en && !done) begin
      int e;
      e = exp_rd();
      total++;
      if (int'(bus_rdata) != e) begin
        bad++;
        $display("FAIL %s: addr=%h actual=%h expected=%h", cur_req, bus_addr, bus_rdata, e[7:0]);
      end
    end
  end

  task automatic drv(input bit c, input bit w, input bit r,
                     input logic [3:0] a, input logic [7:0] d, input bit t);
    @(posedge clk); #2;
    bus_cs = c; bus_we = w; bus_re = r; bus_addr = a; bus_wdata = d; sec_tick = t;
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    drv(1, 1, 0, a, d, 0);
  endtask

  task automatic rd_all();
    for (int i = 0; i < 16; i++) drv(1, 0, 1, 4'(i), 8'h00, 0);
  endtask

  task automatic tk(input int cnt);
    for (int i = 0; i < cnt; i++) begin
      drv(1, 0, 1, 4'h9, 8'h00, 1);
      drv(1, 0, 1, 4'h9, 8'h00, 0);
    end
  endtask

  task automatic set_time(input logic [7:0] cen, input logic [7:0] yr, input logic [7:0] mo,
                          input logic [7:0] dt, input logic [7:0] dw, input logic [7:0] hr,
                          input logic [7:0] mi, input logic [7:0] se);
    wr(4'h8, 8'h80);
    wr(4'hF, yr); wr(4'hE, mo); wr(4'hD, dt); wr(4'hC, dw);
    wr(4'hB, hr); wr(4'hA, mi); wr(4'h9, se);
    wr(4'h8, {2'b00, cen[5:0]});
    rd_all();
  endtask

  task automatic summary();
    $display("test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1; chk_en = 1;

    cur_req = "R1"; rd_all();
    cur_req = "R2"; drv(0, 0, 1, 4'h9, 8'h00, 0); drv(1, 0, 0, 4'hD, 8'h00, 0); rd_all();
    cur_req = "R7"; tk(3); rd_all();

    cur_req = "R10";
    wr(4'h9, 8'h80); tk(3); rd_all();
    wr(4'h9, 8'h00); tk(2); rd_all();

    cur_req = "R9";
    wr(4'h8, 8'h80); wr(4'hB, 8'h12); tk(2); rd_all();
    wr(4'h8, 8'h19); rd_all(); tk(1); rd_all();

    cur_req = "R3"; set_time(8'h20, 8'h23, 8'h06, 8'h14, 8'h07, 8'h23, 8'h59, 8'h58); tk(2); rd_all();
    cur_req = "R5"; set_time(8'h20, 8'h24, 8'h02, 8'h28, 8'h03, 8'h23, 8'h59, 8'h59); tk(1); rd_all();
    set_time(8'h20, 8'h24, 8'h02, 8'h29, 8'h04, 8'h23, 8'h59, 8'h59); tk(1); rd_all();
    set_time(8'h20, 8'h23, 8'h02, 8'h28, 8'h02, 8'h23, 8'h59, 8'h59); tk(1); rd_all();
    cur_req = "R4"; set_time(8'h20, 8'h23, 8'h04, 8'h30, 8'h01, 8'h23, 8'h59, 8'h59); tk(1); rd_all();
    set_time(8'h20, 8'h23, 8'h01, 8'h31, 8'h05, 8'h23, 8'h59, 8'h59); tk(1); rd_all();
    set_time(8'h20, 8'h23, 8'h07, 8'h30, 8'h05, 8'h23, 8'h59, 8'h59); tk(1); rd_all();
    cur_req = "R6"; set_time(8'h19, 8'h99, 8'h12, 8'h31, 8'h06, 8'h23, 8'h59, 8'h59); tk(1); rd_all();
    set_time(8'h39, 8'h99, 8'h12, 8'h31, 8'h06, 8'h23, 8'h59, 8'h59); tk(1); rd_all();
    set_time(8'h05, 8'h41, 8'h11, 8'h30, 8'h02, 8'h23, 8'h59, 8'h59); tk(1); rd_all();

    cur_req = "R8";
    wr(4'h8, 8'h40); tk(4); rd_all();
    wr(4'h8, 8'h00); rd_all(); tk(1); rd_all();

    cur_req = "R12";
    drv(1, 1, 0, 4'hA, 8'h33, 1); drv(1, 0, 1, 4'hA, 8'h00, 0); rd_all(); tk(1); rd_all();

    cur_req = "R11";
    wr(4'hC, 8'h45); tk(2); rd_all();

    cur_req = "R13";
    wr(4'h2, 8'hFF); wr(4'h7, 8'hFF); wr(4'hC, 8'hB3); rd_all(); tk(1); rd_all();

    cur_req = "R11";
    wr(4'hC, 8'h46);
    @(posedge clk); #2 chk_en = 0; rst_n = 1'b0;
    bus_cs = 0; bus_we = 0; bus_re = 0; sec_tick = 0;
    repeat (2) @(posedge clk);
    #2 rst_n = 1'b1; chk_en = 1;
    cur_req = "R1"; rd_all();

    drv(0, 0, 0, 4'h0, 8'h00, 0);
    done = 1;
    summary();
    $finish;
  end

endmodule